// File: doc/BRIEF.md
# Fault Supervisor for a Flyback Switching Controller

This block watches the digital fault flags of a switching power-supply controller and decides, cycle by cycle, whether the power switch may be driven. Each flag is first qualified. It must stay asserted inside its own qualifying window for its own blanking time before it counts as a confirmed fault. Some flags are watched at all times, one only while the switch conducts, and one only while it is off.

Confirmed faults fall into two classes. Supply undervoltage, supply overvoltage, over-temperature and feedback overload are restartable. The supervisor holds the gate off until all of those flags have cleared, then issues a single restart pulse and begins a new stepped soft-start. Output overvoltage and shorted-winding faults are latching. They keep the gate off until a reset.

The soft-start output is a step index, 0 to 4, that a downstream current-limit stage turns into a peak current level. The index rises one step per fixed interval after reset and after every restart.

Top module: `prot_supervisor`

## Requirements
- R1: After a synchronous reset, gate_dis_o, restart_o and latched_o are 0 and ss_step_o is 0.
- R2: A restartable flag (uv_i, ov_i and otp_i with BLANK_SUP; ovl_i with BLANK_OVL) held high for N consecutive cycles raises gate_dis_o within the cycle where it has been seen at N-1 rising edges, that is, the same cycle the fault is confirmed. The gate then stays disabled and latched_o stays 0.
- R3: An overload pulse shorter than BLANK_OVL confirms nothing, and a single low cycle restarts the overload timer from zero.
- R4: Output overvoltage (ovp_i) is counted only while gate_on_i is 0. Once it is held for BLANK_OVP cycles, gate_dis_o rises, and latched_o is 1 one cycle later. While gate_on_i is 1, ovp_i has no effect.
- R5: A shorted winding (sw_i) is counted only while gate_on_i is 1. Once it is held for BLANK_SW cycles, gate_dis_o rises, and latched_o is 1 one cycle later. While gate_on_i is 0, sw_i has no effect.
- R6: Once latched_o is 1, it and gate_dis_o stay 1 until rst_n is low at a clock edge, even after every flag clears, and restart_o stays 0.
- R7: When a latching and a restartable fault are confirmed in the same cycle, the latched shutdown wins: latched_o becomes 1 and no restart pulse follows.
- R8: After a restartable fault, the gate stays disabled while any restartable flag is high. In the cycle after the last one clears, restart_o is 1 for exactly one cycle, gate_dis_o returns to 0 and ss_step_o is 0.
- R9: ss_step_o counts 0, 1, 2, 3, 4 (lowest to full current limit). It advances once every STEP_CYC cycles of normal operation, starting from reset or restart, and holds at 4.
- R10: A drop of the qualifying window (gate_on_i toggling) clears a fault timer just as a drop of the flag does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the only way to clear a latched fault |
| uv_i | input | 1 | Supply below undervoltage level |
| ov_i | input | 1 | Supply above overvoltage level |
| otp_i | input | 1 | Die over-temperature |
| ovl_i | input | 1 | Feedback above overload / open-loop level |
| ovp_i | input | 1 | Zero-crossing sense above output-overvoltage level |
| sw_i | input | 1 | Current sense above shorted-winding level |
| gate_on_i | input | 1 | Current state of the power switch drive, 1 = conducting |
| gate_dis_o | output | 1 | 1 forces the gate drive off |
| restart_o | output | 1 | One-cycle pulse that starts a fresh soft-start |
| latched_o | output | 1 | Latched shutdown active |
| ss_step_o | output | 3 | Soft-start current-limit step, 0 to 4 |

## Verification
The assertions assume every flag and gate_on_i are already synchronous to clk, and that rst_n is held low for at least one edge before operation starts. The window assertions also assume the gate state seen by the supervisor is the same one its qualifiers use, which holds because both read the same input. The stimulus only changes inputs at the falling clock edge and keeps gate_on_i steady through each qualification run, except where R10 deliberately toggles it.

// File: rtl/prot_pkg.sv
// Shared definitions for the fault supervisor.
// Assumes the fault vector is ordered as listed below; restartable faults
// occupy the low bits, latching faults the high bits.
package prot_pkg;

    localparam int NFAULT  = 6;
    localparam int F_UV    = 0;
    localparam int F_OV    = 1;
    localparam int F_OTP   = 2;
    localparam int F_OVL   = 3;
    localparam int F_OVP   = 4;
    localparam int F_SW    = 5;
    localparam int NRESTART = 4;

    localparam logic [NFAULT-1:0] RESTART_MASK = 6'b001111;
    localparam logic [NFAULT-1:0] LATCH_MASK   = 6'b110000;

    localparam int SS_LAST = 4;
    localparam int SS_W    = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_LATCH = 2'd2
    } sup_state_t;

endpackage

// File: rtl/fault_blanker.sv
// Qualifies one fault flag: counts consecutive cycles in which the flag is
// high inside its window and reports a hit once BLANK cycles are reached.
// Assumes flag_i and window_i are synchronous to clk. BLANK >= 1.
module fault_blanker #(
    parameter int BLANK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic window_i,
    output logic hit_o
);

    localparam int CW = (BLANK > 1) ? $clog2(BLANK) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLANK - 1);

    logic          active;
    logic [CW-1:0] cnt_q;

    assign active = flag_i & window_i;
    assign hit_o  = active & (cnt_q == LAST);

    // Count qualified cycles, saturate at LAST, clear on any gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (BLANK > 1) begin : g_hist
            AST_HIT_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> $past(active)); // R3
        end
    endgenerate

endmodule

// File: rtl/ss_ramp.sv
// Stepped soft-start: step index rises by one every STEP_CYC cycles while
// run_i is high and holds at SS_LAST; it returns to 0 whenever run_i is low.
// Assumes run_i is low for at least one cycle before each restart.
module ss_ramp
    import prot_pkg::*;
#(
    parameter int STEP_CYC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    output logic [SS_W-1:0] step_o
);

    localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(STEP_CYC - 1);
    localparam logic [SS_W-1:0] S_LAST = SS_W'(SS_LAST);

    logic [TW-1:0]   tmr_q;
    logic [SS_W-1:0] step_q;

    assign step_o = step_q;

    // Advance the step timer and the step index.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            tmr_q  <= '0;
            step_q <= '0;
        end else if (step_q != S_LAST) begin
            if (tmr_q == T_LAST) begin
                tmr_q  <= '0;
                step_q <= step_q + 1'b1;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_o <= S_LAST); // R9
    AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> (step_o >= $past(step_o))); // R9

endmodule

// File: rtl/sup_arbiter.sv
// Decides between normal run, restart hold and latched shutdown from the
// confirmed fault hits. Latching hits take priority; a hold ends when all
// raw restartable flags are low, with a one-cycle restart pulse.
// Assumes hit_i bits follow the ordering in prot_pkg.
module sup_arbiter
    import prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFAULT-1:0] hit_i,
    input  logic              raw_restart_i,
    output sup_state_t        state_o,
    output logic              restart_o
);

    sup_state_t state_q;
    logic       restart_q;
    logic       lat_hit;
    logic       ar_hit;

    assign lat_hit   = |(hit_i & LATCH_MASK);
    assign ar_hit    = |(hit_i & RESTART_MASK);
    assign state_o   = state_q;
    assign restart_o = restart_q;

    // State transitions and restart pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (lat_hit)     state_q <= ST_LATCH;
                    else if (ar_hit) state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (lat_hit) begin
                        state_q <= ST_LATCH;
                    end else if (!raw_restart_i) begin
                        state_q   <= ST_RUN;
                        restart_q <= 1'b1;
                    end
                end
                default: state_q <= ST_LATCH;
            endcase
        end
    end

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |=> (state_q == ST_LATCH)); // R6
    AST_LATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_hit && ar_hit) |=> (state_q == ST_LATCH && !restart_q)); // R7
    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q); // R8

endmodule

// File: rtl/prot_supervisor.sv
// Top of the fault supervisor: one blanking qualifier per fault, the
// restart/latch arbiter and the stepped soft-start. The gate is disabled
// combinationally in the cycle a fault is confirmed and held off by state.
// Assumes all inputs are synchronous to clk.
module prot_supervisor
    import prot_pkg::*;
#(
    parameter int BLANK_SUP = 3,
    parameter int BLANK_OVL = 1200000,
    parameter int BLANK_OVP = 5000,
    parameter int BLANK_SW  = 10,
    parameter int STEP_CYC  = 150000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            uv_i,
    input  logic            ov_i,
    input  logic            otp_i,
    input  logic            ovl_i,
    input  logic            ovp_i,
    input  logic            sw_i,
    input  logic            gate_on_i,
    output logic            gate_dis_o,
    output logic            restart_o,
    output logic            latched_o,
    output logic [SS_W-1:0] ss_step_o
);

    function automatic int blank_of(int idx);
        case (idx)
            F_OVL:   return BLANK_OVL;
            F_OVP:   return BLANK_OVP;
            F_SW:    return BLANK_SW;
            default: return BLANK_SUP;
        endcase
    endfunction

    logic [NFAULT-1:0] flags;
    logic [NFAULT-1:0] windows;
    logic [NFAULT-1:0] hits;
    sup_state_t        state;

    assign flags = {sw_i, ovp_i, ovl_i, otp_i, ov_i, uv_i};

    // Qualifying windows: shorted winding on-time, output OVP off-time, rest always.
    always_comb begin
        windows        = '1;
        windows[F_OVP] = ~gate_on_i;
        windows[F_SW]  = gate_on_i;
    end

    generate
        for (genvar i = 0; i < NFAULT; i++) begin : g_qual
            fault_blanker #(
                .BLANK (blank_of(i))
            ) u_blank (
                .clk      (clk),
                .rst_n    (rst_n),
                .flag_i   (flags[i]),
                .window_i (windows[i]),
                .hit_o    (hits[i])
            );
        end
    endgenerate

    sup_arbiter u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit_i         (hits),
        .raw_restart_i (|flags[NRESTART-1:0]),
        .state_o       (state),
        .restart_o     (restart_o)
    );

    ss_ramp #(
        .STEP_CYC (STEP_CYC)
    ) u_ss (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_RUN),
        .step_o (ss_step_o)
    );

    assign gate_dis_o = (state != ST_RUN) | (|hits);
    assign latched_o  = (state == ST_LATCH);

    AST_OVP_OFFTIME: assert property (@(posedge clk) disable iff (!rst_n)
        hits[F_OVP] |-> !gate_on_i); // R4
    AST_SW_ONTIME: assert property (@(posedge clk) disable iff (!rst_n)
        hits[F_SW] |-> gate_on_i); // R5
    AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o || restart_o === 1'b0 && state == ST_HOLD) |-> gate_dis_o); // R2

endmodule

// File: tb/sim_prot_supervisor.sv
`timescale 1ns/1ps
module sim_prot_supervisor;

    localparam int BS   = 3;
    localparam int BOVL = 20;
    localparam int BOVP = 6;
    localparam int BSW  = 4;
    localparam int STEP = 8;

    typedef struct packed {
        logic [2:0] fid;
        logic       gate;
        logic [7:0] hold;
        logic       dis;
        logic       lat;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 1'b0, 8'(BS-2),   1'b0, 1'b0, 4'd2},  // R2 UV short
        '{3'd0, 1'b0, 8'(BS-1),   1'b1, 1'b0, 4'd2},  // R2 UV confirmed
        '{3'd1, 1'b0, 8'(BS-1),   1'b1, 1'b0, 4'd2},  // R2 OV confirmed
        '{3'd2, 1'b0, 8'(BS-1),   1'b1, 1'b0, 4'd2},  // R2 OTP confirmed
        '{3'd3, 1'b0, 8'(BOVL-2), 1'b0, 1'b0, 4'd3},  // R3 overload short
        '{3'd3, 1'b0, 8'(BOVL-1), 1'b1, 1'b0, 4'd2},  // R2 overload confirmed
        '{3'd4, 1'b0, 8'(BOVP-1), 1'b1, 1'b1, 4'd4},  // R4 OVP off-time
        '{3'd4, 1'b1, 8'(10),     1'b0, 1'b0, 4'd4},  // R4 OVP ignored on-time
        '{3'd5, 1'b1, 8'(BSW-1),  1'b1, 1'b1, 4'd5},  // R5 SW on-time
        '{3'd5, 1'b0, 8'(10),     1'b0, 1'b0, 4'd5},  // R5 SW ignored off-time
        '{3'd5, 1'b1, 8'(BSW-2),  1'b0, 1'b0, 4'd5}   // R5 SW short
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] flt = '0;
    logic       gate_on = 1'b0;
    logic       gate_dis, restart, latched;
    logic [2:0] step;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prot_supervisor #(
        .BLANK_SUP (BS), .BLANK_OVL (BOVL), .BLANK_OVP (BOVP),
        .BLANK_SW (BSW), .STEP_CYC (STEP)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .uv_i (flt[0]), .ov_i (flt[1]), .otp_i (flt[2]), .ovl_i (flt[3]),
        .ovp_i (flt[4]), .sw_i (flt[5]), .gate_on_i (gate_on),
        .gate_dis_o (gate_dis), .restart_o (restart),
        .latched_o (latched), .ss_step_o (step)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        flt = '0; gate_on = 1'b0; rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        tick(1);
        // R1 reset state
        do_reset();
        chk("R1", "gate_dis", gate_dis, 0);
        chk("R1", "restart", restart, 0);
        chk("R1", "latched", latched, 0);
        chk("R1", "step", step, 0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            string rq;
            do_reset();
            rq = $sformatf("R%0d", TBL[v].req);
            gate_on = TBL[v].gate;
            flt[TBL[v].fid] = 1'b1;
            tick(int'(TBL[v].hold));
            chk(rq, $sformatf("vec%0d gate_dis", v), gate_dis, TBL[v].dis);
            tick(1);
            chk(rq, $sformatf("vec%0d latched", v), latched, TBL[v].lat);
            flt = '0;
        end

        // R9 soft-start progression and saturation
        do_reset();
        tick(STEP-1);
        chk("R9", "step before first", step, 0);
        tick(1);
        chk("R9", "step first", step, 1);
        tick(3*STEP);
        chk("R9", "step full", step, 4);
        tick(3*STEP);
        chk("R9", "step held", step, 4);
        chk("R9", "gate_dis", gate_dis, 0);

        // R8 restart after restartable fault
        do_reset();
        tick(2*STEP);
        chk("R8", "step pre-fault", step, 2);
        flt[0] = 1'b1;
        tick(BS);
        chk("R8", "hold restart", restart, 0);
        chk("R8", "hold latched", latched, 0);
        tick(5);
        chk("R8", "hold gate_dis", gate_dis, 1);
        flt[0] = 1'b0;
        tick(1);
        chk("R8", "restart pulse", restart, 1);
        chk("R8", "gate re-enabled", gate_dis, 0);
        chk("R8", "step reset", step, 0);
        tick(1);
        chk("R8", "pulse one cycle", restart, 0);

        // R3 overload timer restarts after a gap
        do_reset();
        flt[3] = 1'b1; tick(15);
        flt[3] = 1'b0; tick(1);
        flt[3] = 1'b1; tick(BOVL-2);
        chk("R3", "gap restarted timer", gate_dis, 0);
        tick(1);
        chk("R3", "confirm after full run", gate_dis, 1);
        flt = '0;

        // R10 window drop clears the OVP timer
        do_reset();
        flt[4] = 1'b1; tick(BOVP-2);
        gate_on = 1'b1; tick(1);
        gate_on = 1'b0; tick(BOVP-2);
        chk("R10", "no confirm", gate_dis, 0);
        chk("R10", "not latched", latched, 0);
        tick(1);
        chk("R10", "confirm", gate_dis, 1);
        tick(1);
        chk("R10", "latched", latched, 1);

        // R7 simultaneous latching and restartable confirmation
        do_reset();
        gate_on = 1'b1;
        flt[5] = 1'b1; tick(1);
        flt[0] = 1'b1; tick(BSW-2);
        chk("R7", "gate_dis", gate_dis, 1);
        tick(1);
        chk("R7", "latched wins", latched, 1);
        chk("R7", "no restart", restart, 0);

        // R6 latch persists after flags clear
        flt = '0; gate_on = 1'b0;
        tick(6);
        chk("R6", "latched held", latched, 1);
        chk("R6", "gate held", gate_dis, 1);
        chk("R6", "no restart", restart, 0);
        do_reset();
        chk("R6", "reset clears latch", latched, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule